// File: doc/BRIEF.md
# I2C Bus Address Scanner

This block is a bus controller engine that walks the whole legal 7-bit target address space and reports which addresses answer. A single start pulse begins a sweep. For each candidate address the engine opens a transaction with a START condition and shifts out the address byte with the write direction bit. It then releases the data line for the acknowledge clock, samples it, and closes with a STOP. No data bytes are ever sent. Addresses at both ends of the map that the bus standard keeps for special functions are never placed on the bus.

Both bus lines are open-drain. The engine has two drive-low enables and two sampled line inputs, and it never drives a line high. The bit rate is set by the parameter `CLK_DIV`: every bit is four phases of `CLK_DIV` clock cycles each. The sweep result is a 128-bit presence map, one bit per address, which is valid while `done_o` is high.

The control is one state machine. `ST_IDLE` goes to `ST_START` on an accepted start pulse. `ST_START` goes to `ST_BIT` after four phases. `ST_BIT` stays in `ST_BIT` for nine bit slots (eight address bits, then the acknowledge) and then goes to `ST_STOP`. `ST_STOP` goes to `ST_GAP`. `ST_GAP` goes back to `ST_START` for the next address, or to `ST_IDLE` with `done_o` raised after the last address.

Top module: `i2c_addr_scanner`

## Requirements
- R1: Only addresses 0x08 to 0x77 are placed on the bus, one probe each, in ascending order. The reserved addresses 0x00–0x07 and 0x78–0x7F are never sent.
- R2: Each probe has four parts in this order: START, the byte {address[6:0], 1'b0} sent MSB first, one acknowledge clock, then STOP. No data byte follows. START is SDA falling while SCL is released (high). STOP is SDA rising while SCL is released.
- R3: A bit slot is four phases of CLK_DIV cycles. SCL is driven low in phases 0 and 1 and released in phases 2 and 3. Outside START and STOP, SDA changes only on entry to phase 1, while SCL is low. Both outputs are drive-low enables (1 = pull low).
- R4: The controller releases SDA from phase 1 of the acknowledge slot until the STOP begins.
- R5: The acknowledge is sampled in the last cycle of phase 3 of the acknowledge slot. SDA low (with SCL high) sets the address's presence bit, and SDA high clears it.
- R6: After a sweep, presence bits 0–7 and 120–127 read 0, whatever answered on the bus.
- R7: Between each STOP and the next START, and after the last STOP, both lines stay released for one full bit period (four phases).
- R8: A start pulse that arrives while a sweep is running is ignored. The sweep continues unchanged.
- R9: `busy_o` rises in the cycle after an accepted start pulse and `done_o` clears at the same time. When the sweep ends, `busy_o` is low and `done_o` is high. `done_o` and the presence map then hold until the next start pulse.
- R10: After reset both lines are released, `busy_o` and `done_o` are low, and the presence map is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle pulse that begins a sweep |
| busy_o | output | 1 | High while a sweep is running |
| done_o | output | 1 | High once a sweep has finished; the map is valid |
| present_o | output | 128 | Presence map; bit n is set when address n acknowledged |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
An accepted start pulse takes effect at the next rising edge. From the cycle after that edge, the bench model expects line-drive phase k to occupy cycles k*CLK_DIV through k*CLK_DIV+CLK_DIV-1. The model compares both drive enables against its own schedule once per clock, at the falling edge. The sweep end is due in the cycle right after the last idle-gap phase. The bench checks `busy_o`, `done_o` and the whole presence map in exactly that cycle, so an extra or missing cycle anywhere in the sweep shows up there. A target model on the resolved lines decodes each address byte and acknowledges from its own table. It checks the order, the direction bit and that no reserved address appears, so bus-level correctness is judged apart from the cycle schedule.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int ADDR_W       = 7;
    localparam int MAP_W        = 1 << ADDR_W;
    localparam int FIRST_ADDR   = 8;
    localparam int LAST_ADDR    = 119;
    localparam int SLOTS        = 9;
    localparam int SLOT_W       = $clog2(SLOTS + 1);
    localparam int ACK_SLOT     = SLOTS - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP,
        ST_GAP
    } scan_state_e;

    typedef logic [1:0] phase_t;

endpackage

// File: rtl/scan_tick.sv
module scan_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (hold || cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = !hold && (cnt_q == '0);

endmodule

// File: rtl/scan_addr.sv
module scan_addr
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(FIRST_ADDR);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(LAST_ADDR);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= A_FIRST;
        end else if (load) begin
            addr_q <= A_FIRST;
        end else if (step && addr_q != A_LAST) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == A_LAST);

endmodule

// File: rtl/scan_bitmap.sv
module scan_bitmap
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wval,
    output logic [MAP_W-1:0]  map
);
    for (genvar i = 0; i < MAP_W; i++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else if (clr) begin
                cell_q <= 1'b0;
            end else if (wr && waddr == ADDR_W'(i)) begin
                cell_q <= wval;
            end
        end
        assign map[i] = cell_q;
    end

endmodule

// File: rtl/i2c_addr_scanner.sv
module i2c_addr_scanner
    import scan_pkg::*;
#(
    parameter int CLK_DIV = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [MAP_W-1:0] present_o,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    input  logic             scl_i,
    input  logic             sda_i
);
    localparam phase_t PH_LAST = 2'd3;
    localparam logic [SLOT_W-1:0] SLOT_ACK = SLOT_W'(ACK_SLOT);

    scan_state_e       state_q, state_d;
    phase_t            phase_q, phase_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              sda_q, done_q;

    logic              tick;
    logic              accept;
    logic              phase_end;
    logic              addr_step;
    logic              addr_last;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        tx_byte;
    logic              tx_bit;
    logic              ack_wr;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign phase_end = tick && (phase_q == PH_LAST);
    assign addr_step = phase_end && (state_q == ST_GAP) && !addr_last;
    assign ack_wr    = phase_end && (state_q == ST_BIT) && (slot_q == SLOT_ACK);
    assign tx_byte   = {cur_addr, 1'b0};
    assign tx_bit    = tx_byte[3'd7 - slot_q[2:0]];

    scan_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (state_q == ST_IDLE),
        .tick  (tick)
    );

    scan_addr u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (addr_step),
        .addr  (cur_addr),
        .last  (addr_last)
    );

    scan_bitmap u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .wr    (ack_wr),
        .waddr (cur_addr),
        .wval  (scl_i && !sda_i),
        .map   (present_o)
    );

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        slot_d  = slot_q;
        if (tick) begin
            phase_d = phase_q + 2'd1;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_START;
                    phase_d = '0;
                    slot_d  = '0;
                end
            end
            ST_START: begin
                if (phase_end) begin
                    state_d = ST_BIT;
                    slot_d  = '0;
                end
            end
            ST_BIT: begin
                if (phase_end) begin
                    if (slot_q == SLOT_ACK) begin
                        state_d = ST_STOP;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (phase_end) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (phase_end) begin
                    state_d = addr_last ? ST_IDLE : ST_START;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            slot_q  <= slot_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                done_q <= 1'b0;
            end
            if (tick) begin
                unique case (state_q)
                    ST_START: begin
                        if (phase_q == 2'd1) sda_q <= 1'b1;
                    end
                    ST_BIT: begin
                        if (phase_q == 2'd0) begin
                            sda_q <= (slot_q == SLOT_ACK) ? 1'b0 : !tx_bit;
                        end
                    end
                    ST_STOP: begin
                        if (phase_q == 2'd0) sda_q <= 1'b1;
                        if (phase_q == 2'd2) sda_q <= 1'b0;
                    end
                    ST_GAP: begin
                        if (phase_q == PH_LAST && addr_last) done_q <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign sda_oe_o = sda_q;
    assign scl_oe_o = ((state_q == ST_BIT) || (state_q == ST_STOP)) && !phase_q[1];

endmodule

// File: rtl/scan_checker.sv
module scan_checker
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_o,
    input  logic              done_o,
    input  logic [MAP_W-1:0]  present_o,
    input  logic              scl_oe_o,
    input  logic              sda_oe_o,
    input  scan_state_e       st,
    input  phase_t            phase,
    input  logic [SLOT_W-1:0] slot,
    input  logic [ADDR_W-1:0] addr
);
    p_addr_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (addr >= ADDR_W'(FIRST_ADDR) && addr <= ADDR_W'(LAST_ADDR)));

    p_sda_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && st != ST_START && st != ST_STOP) |-> scl_oe_o);

    p_ack_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BIT && slot == SLOT_W'(ACK_SLOT) && phase != 2'd0) |-> !sda_oe_o);

    p_reserved_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (present_o[7:0] == '0 && present_o[MAP_W-1:LAST_ADDR+1] == '0));

    p_gap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> (!scl_oe_o && !sda_oe_o));

    p_busy_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && st != ST_GAP) |=> $stable(addr));

    p_start_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(present_o)));

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

endmodule

bind i2c_addr_scanner scan_checker u_scan_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .present_o (present_o),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .st        (state_q),
    .phase     (phase_q),
    .slot      (slot_q),
    .addr      (cur_addr)
);

// File: tb/i2c_addr_scanner_tb.sv
module i2c_addr_scanner_tb_top;
    localparam int DIV = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic         start_i;
    logic         busy, done, scl_oe, sda_oe;
    logic [127:0] present;
    logic         tgt_low = 1'b0;

    wire scl_line = ~scl_oe;
    wire sda_line = ~(sda_oe | tgt_low);

    i2c_addr_scanner #(.CLK_DIV(DIV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .busy_o    (busy),
        .done_o    (done),
        .present_o (present),
        .scl_oe_o  (scl_oe),
        .sda_oe_o  (sda_oe),
        .scl_i     (scl_line),
        .sda_i     (sda_line)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic string seg_tag(input logic [1:0] s);
        case (s)
            2'd0: return "R3 start/bit";
            2'd1: return "R4 ack slot";
            2'd2: return "R7 idle gap";
            default: return "R2 stop";
        endcase
    endfunction

    // Reference model: one entry per clock, {segment, scl_oe, sda_oe}
    logic [3:0]   q[$];
    logic [3:0]   ent;
    bit           m_busy = 0;
    bit           pend_done = 0;
    bit           extra_seen = 0;
    logic [127:0] ack_map;
    logic [127:0] exp_map;
    int           exp_addr;

    task automatic put(input logic [1:0] seg, input logic scl, input logic sda);
        for (int c = 0; c < DIV; c++) q.push_back({seg, scl, sda});
    endtask

    task automatic build_model();
        exp_map = '0;
        for (int a = 0; a < 128; a++)
            exp_map[a] = (a >= 8 && a <= 119) ? ack_map[a] : 1'b0;
        for (int a = 8; a <= 119; a++) begin
            logic [7:0] b;
            logic       prev;
            b = {a[6:0], 1'b0};
            put(2'd0, 1'b0, 1'b0); put(2'd0, 1'b0, 1'b0);
            put(2'd0, 1'b0, 1'b1); put(2'd0, 1'b0, 1'b1);
            prev = 1'b1;
            for (int i = 7; i >= 0; i--) begin
                put(2'd0, 1'b1, prev);
                put(2'd0, 1'b1, ~b[i]);
                put(2'd0, 1'b0, ~b[i]);
                put(2'd0, 1'b0, ~b[i]);
                prev = ~b[i];
            end
            put(2'd1, 1'b1, prev); put(2'd1, 1'b1, 1'b0);
            put(2'd1, 1'b0, 1'b0); put(2'd1, 1'b0, 1'b0);
            put(2'd3, 1'b1, 1'b0); put(2'd3, 1'b1, 1'b1);
            put(2'd3, 1'b0, 1'b1); put(2'd3, 1'b0, 1'b0);
            for (int g = 0; g < 4; g++) put(2'd2, 1'b0, 1'b0);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && start_i && !m_busy) begin
            build_model();
            exp_addr = 8;
            m_busy = 1;
        end
    end

    always @(negedge clk) begin
        if (q.size() > 0) begin
            ent = q.pop_front();
            chk({scl_oe, sda_oe} == ent[1:0], seg_tag(ent[3:2]), {scl_oe, sda_oe}, ent[1:0]);
            if (q.size() == 0) pend_done = 1;
        end else if (pend_done) begin
            chk(!busy && done, "R9 end of sweep", {busy, done}, 2'b01);
            if (extra_seen) chk(!busy && done, "R8 no restart", {busy, done}, 2'b01);
            chk(present == exp_map, "R5 presence map", present, exp_map);
            chk(present[7:0] == 0 && present[127:120] == 0, "R6 reserved bits", present, exp_map);
            chk(exp_addr == 120, "R1 probe count", exp_addr, 120);
            pend_done = 0;
            extra_seen = 0;
            m_busy = 0;
        end
    end

    // Target model on the resolved lines
    bit         t_act = 0;
    int         t_cnt = 0;
    logic [7:0] t_sh = '0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin t_act = 1; t_cnt = 0; end
    always @(posedge sda_line) if (scl_line === 1'b1) t_act = 0;

    always @(posedge scl_line) begin
        if (t_act && t_cnt < 9) begin
            if (t_cnt < 8) t_sh = {t_sh[6:0], sda_line};
            t_cnt++;
            if (t_cnt == 8) begin
                chk(t_sh[7:1] >= 8 && t_sh[7:1] <= 119, "R1 legal address", t_sh[7:1], exp_addr);
                chk(t_sh[7:1] == exp_addr[6:0], "R1 ascending order", t_sh[7:1], exp_addr);
                chk(t_sh[0] == 1'b0, "R2 write bit", t_sh[0], 0);
                exp_addr++;
            end
        end
    end

    always @(negedge scl_line) begin
        if (t_act) begin
            if (t_cnt == 8 && ack_map[t_sh[7:1]]) tgt_low = 1'b1;
            else if (t_cnt == 9) tgt_low = 1'b0;
        end
    end

    task automatic run_scan(input bit extra);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy && !done, "R9 busy after start", {busy, done}, 2'b10);
        if (extra) begin
            repeat (3000) @(negedge clk);
            extra_seen = 1;
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        while (m_busy) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        start_i = 1'b0;
        ack_map = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
        chk(!busy && !done, "R10 flags", {busy, done}, 0);
        chk(present == '0, "R10 map clear", present, 0);

        ack_map = '0;
        ack_map[8'h00] = 1'b1; ack_map[8'h08] = 1'b1; ack_map[8'h3C] = 1'b1;
        ack_map[8'h50] = 1'b1; ack_map[8'h77] = 1'b1; ack_map[8'h7F] = 1'b1;
        run_scan(1'b1);

        repeat (10) @(negedge clk);
        chk(done && !busy, "R9 done held", {busy, done}, 2'b01);
        chk(present == exp_map, "R9 map held", present, exp_map);

        ack_map = '0;
        ack_map[8'h09] = 1'b1; ack_map[8'h21] = 1'b1;
        ack_map[8'h76] = 1'b1; ack_map[8'h78] = 1'b1;
        run_scan(1'b0);
        chk(!present[8'h3C] && !present[8'h50], "R5 stale bits cleared", present, exp_map);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule